// File: doc/BRIEF.md
# Dither Pattern RAM Host Access Port

This block lets a host program and inspect a 64-entry, 32-bit pattern memory that a pixel pipeline reads while it runs. The host sees two registers. The control register holds an access bit, an update bit and a 6-bit pointer. Each strobe on the 32-bit data register writes or reads the entry at the pointer and then moves the pointer on by one. A block of consecutive entries can therefore be loaded after a single pointer write. Any jump to another place in the memory needs a new pointer write first.

The memory is usable only when four bits are all set. Two of them are the access and update bits of the control register. The other two come from the dither control register: a bit that selects the programmable memory, and the dither enable. If any of the four is clear, the memory is in power-down. In that state host strobes do nothing, and the pixel read port gives zero.

Top module: `dpat_ram_port`

## Requirements
- R1: After reset, ctl_rdata, host_rdata and pix_data are all zero.
- R2: A ctl_we strobe loads ctl_wdata into the control register. The fields are: access bit 7, update bit 6, pointer bits 5:0. The value shows on ctl_rdata in the next cycle.
- R3: The memory is active only while control bit 7, control bit 6, ram_sel and dith_en are all 1. Otherwise it is in power-down.
- R4: A host_we strobe while the memory is active stores host_wdata in the entry at the pointer and increments the pointer by one.
- R5: A host_re strobe while the memory is active puts the entry at the current pointer on host_rdata in the next cycle, then increments the pointer. host_rdata holds its value until the next effective read.
- R6: The pointer wraps from 63 to 0 on increment.
- R7: A host data strobe during power-down leaves the memory and the pointer unchanged. A read in that state returns zero on host_rdata in the next cycle.
- R8: pix_data, one cycle after pix_addr is presented, holds that entry while the memory is active, and zero in power-down.
- R9: When ctl_we arrives in the same cycle as a host data strobe, the control write takes effect and the data strobe is ignored.
- R10: When host_we and host_re arrive together, only the write is performed, and host_rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_sel | input | 1 | Programmable memory selected (from dither control) |
| dith_en | input | 1 | Dither enable (from dither control) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value {access, update, pointer} |
| ctl_rdata | output | 8 | Control register contents |
| host_we | input | 1 | Data register write strobe |
| host_wdata | input | 32 | Data register write value |
| host_re | input | 1 | Data register read strobe |
| host_rdata | output | 32 | Data read result, one cycle after the strobe |
| pix_addr | input | 6 | Pixel-side entry index |
| pix_data | output | 32 | Pixel-side entry, one cycle later |

## Verification
The hardest cases to reach are the ones where the gate opens or closes on the same edge as a strobe: a control write arriving together with a data strobe, or one of the four gating bits dropping just before a burst. The bench first fills the whole memory in one wrapping burst, so every entry holds a known value. It then runs random cycles in which the two external gating inputs and the control bits change at random and strobes collide. Directed steps cover a write in power-down followed by a read-back, and an explicit 63-to-0 pointer wrap.

// File: rtl/dpat_ram_port.sv
module dpat_ram_port #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ram_sel,
  input  logic          dith_en,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          host_we,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_re,
  output logic [DW-1:0] host_rdata,
  input  logic [AW-1:0] pix_addr,
  output logic [DW-1:0] pix_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          acc_q, upd_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] rd_q, pix_q;

  wire active = acc_q & upd_q & ram_sel & dith_en;
  wire do_wr  = !ctl_we && host_we && active;
  wire do_rd  = !ctl_we && !host_we && host_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      upd_q <= 1'b0;
      ptr_q <= '0;
      rd_q  <= '0;
      pix_q <= '0;
    end else begin
      pix_q <= active ? mem[pix_addr] : '0;
      if (ctl_we) begin
        acc_q <= ctl_wdata[7];
        upd_q <= ctl_wdata[6];
        ptr_q <= ctl_wdata[AW-1:0];
      end else if (do_wr) begin
        ptr_q <= ptr_q + 1'b1;
      end else if (do_rd) begin
        rd_q <= active ? mem[ptr_q] : '0;
        if (active) ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[ptr_q] <= host_wdata;
  end

  assign ctl_rdata  = {acc_q, upd_q, ptr_q};
  assign host_rdata = rd_q;
  assign pix_data   = pix_q;
endmodule

module dpat_ram_port_chk #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_sel,
  input logic          dith_en,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic [7:0]    ctl_rdata,
  input logic          host_we,
  input logic          host_re,
  input logic [DW-1:0] host_rdata,
  input logic [DW-1:0] pix_data
);
  wire on = ctl_rdata[7] & ctl_rdata[6] & ram_sel & dith_en;

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == $past(ctl_wdata));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && on && (host_we || host_re)) |=>
      ctl_rdata[AW-1:0] == AW'($past(ctl_rdata[AW-1:0]) + 1'b1));

  // R7
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !on && (host_we || host_re)) |=> $stable(ctl_rdata));

  // R7
  gated_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !on && !host_we && host_re) |=> host_rdata == '0);

  // R8
  pix_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> pix_data == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_re || host_we || ctl_we) |=> $stable(host_rdata));
endmodule

bind dpat_ram_port dpat_ram_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ram_sel(ram_sel), .dith_en(dith_en),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
  .pix_data(pix_data)
);

// File: tb/dpat_ram_port_bench.sv
module dpat_ram_port_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ram_sel = 1'b0, dith_en = 1'b0;
  logic        ctl_we = 1'b0, host_we = 1'b0, host_re = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [31:0] host_wdata = '0;
  logic [5:0]  pix_addr = '0;
  logic [7:0]  ctl_rdata;
  logic [31:0] host_rdata, pix_data;

  dpat_ram_port u_dpat_ram_port (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [31:0] rmem [64];
  logic        racc = 0, rupd = 0;
  logic [5:0]  rptr = 0;
  logic [31:0] rrd = 0;

  function automatic logic [7:0] exp_ctl();
    return {racc, rupd, rptr};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit cw, input logic [7:0] cwd, input bit dw,
                      input logic [31:0] dwd, input bit dr, input string tag);
    logic        on;
    logic [31:0] exp_pix;
    @(negedge clk);
    ctl_we = cw; ctl_wdata = cwd; host_we = dw; host_wdata = dwd; host_re = dr;
    on = racc & rupd & ram_sel & dith_en;
    exp_pix = on ? rmem[pix_addr] : 32'h0;
    @(posedge clk); #1;
    if (cw) begin
      racc = cwd[7]; rupd = cwd[6]; rptr = cwd[5:0];
    end else if (dw) begin
      if (on) begin rmem[rptr] = dwd; rptr = rptr + 1; end
    end else if (dr) begin
      rrd = on ? rmem[rptr] : 32'h0;
      if (on) rptr = rptr + 1;
    end
    ctl_we = 0; host_we = 0; host_re = 0;
    chk({tag, " ctl"}, {24'h0, ctl_rdata}, {24'h0, exp_ctl()});
    chk({tag, " rdata"}, host_rdata, rrd);
    chk({tag, " pix"}, pix_data, exp_pix);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h1d17));
    for (int i = 0; i < 64; i++) rmem[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 ctl", {24'h0, ctl_rdata}, 32'h0);
    chk("R1 rdata", host_rdata, 32'h0);
    chk("R1 pix", pix_data, 32'h0);
    @(negedge clk); rst_n = 1;

    // R3: only three of four gate bits set, write must be dropped
    ram_sel = 1; dith_en = 0;
    step(1, 8'hC0, 0, 0, 0, "R2");
    step(0, 0, 1, 32'hDEAD0000, 0, "R3");
    dith_en = 1;

    // R4 R6: fill all 64 entries in one burst, pointer wraps to 0
    for (int i = 0; i < 64; i++) step(0, 0, 1, 32'hA5000000 ^ (i * 32'h01010101), 0, "R4");
    chk("R6 wrap", {26'h0, ctl_rdata[5:0]}, 32'h0);

    // R5 R6: read entry 63 then wrap to 0
    step(1, 8'hFF, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, "R5");
    chk("R6 rd wrap", {26'h0, ctl_rdata[5:0]}, 32'h0);

    // R7: write in power-down, then read back the old value
    keep = rmem[5];
    step(1, 8'h85, 0, 0, 0, "R7");
    step(0, 0, 1, 32'h12345678, 0, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(1, 8'hC5, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, "R7");
    chk("R7 keep", host_rdata, keep);

    // R9: control write collides with a data write
    step(1, 8'hCA, 1, 32'hFFFF0000, 0, "R9");
    // R10: write and read together
    step(0, 0, 1, 32'h0BADBEEF, 1, "R10");

    // R8: pixel port in both states
    pix_addr = 6'd10;
    step(0, 0, 0, 0, 0, "R8");
    ram_sel = 0;
    step(0, 0, 0, 0, 0, "R8");
    ram_sel = 1;

    for (int i = 0; i < 800; i++) begin
      bit cw, dw, dr;
      logic [7:0] cwd;
      ram_sel  = ($urandom % 8) != 0;
      dith_en  = ($urandom % 8) != 0;
      pix_addr = 6'($urandom);
      cw  = ($urandom % 8) == 0;
      cwd = 8'($urandom);
      if (($urandom % 4) != 0) cwd[7:6] = 2'b11;
      dw  = ($urandom % 3) == 0;
      dr  = ($urandom % 2) == 0;
      step(cw, cwd, dw, $urandom, dr, "R5");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule